// File: doc/BRIEF.md
# Floating-Point Greater-Than Comparator with Signed NaN Ranking

This block decides whether operand A is strictly greater than operand B. Both operands are IEEE 754 encodings, either 32-bit single precision or 16-bit half precision. A format select input chooses between them. In half precision only the low 16 bits of each operand word carry the value.

Ordinary values, including infinities and subnormals, are compared by their numeric value. NaN operands are not treated as unordered. They take part in a signed ranking, from top to bottom:

- positive quiet NaN
- positive signalling NaN
- positive infinity
- finite values
- negative infinity
- negative signalling NaN
- negative quiet NaN

The only output is one greater-than flag. A parameter can insert a single register stage in front of that flag. The register delays the flag by one clock and does not change its value.

Top module: `fpgt_compare`

## Requirements
- R1: With no NaN operand, the output is 1 exactly when A is numerically greater than B. This holds for positive, negative and mixed-sign pairs and for infinities.
- R2: Positive zero and negative zero compare as equal, so neither is greater than the other in either order. Two equal non-NaN operands give 0.
- R3: Subnormal operands are compared by value, with no flush to zero. The single-precision encoding 0x00000002 is greater than 0x00000001, and 0x00000001 is greater than +0.
- R4: When at least one operand is a NaN and the two sign bits differ, the output equals the inverse of the sign bit of A.
- R5: When at least one operand is a NaN and both signs are positive, the ranking is quiet NaN above signalling NaN above every non-NaN value. Two positive NaNs of the same class give 0.
- R6: When at least one operand is a NaN and both signs are negative, the positive-sign decision is inverted. As a result, any non-NaN value is above a negative signalling NaN, and that NaN is above a negative quiet NaN. Because of this inversion, two negative NaNs of the same class give 1.
- R7: The format select input picks the encoding: 0 selects single precision on all 32 bits, and 1 selects half precision on bits 15:0. In half-precision mode, bits 31:16 of both operands have no effect on the output.
- R8: An operand is a NaN when its exponent field is all ones and its mantissa is non-zero. A NaN is quiet when the top mantissa bit is 1 and signalling when that bit is 0. An all-ones exponent with a zero mantissa is an infinity and is ranked numerically.
- R9: With the register stage enabled (the default), the output shows the decision for the inputs present at the previous rising clock edge. While the active-low reset is asserted, the output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| fmt_half | input | 1 | 0 = single precision, 1 = half precision on bits 15:0 |
| a_word | input | 32 | Operand A encoding |
| b_word | input | 32 | Operand B encoding |
| gt_out | output | 1 | 1 when A ranks strictly above B |

## Verification
The main function is exercised with an all-pairs sweep over a set of values that covers every class in both formats: signed zeros, subnormals, normals, infinities, and both NaN classes of both signs. Ordered pairs of this set separate the numeric path from the NaN path, and they show whether the sign, the quiet bit or the magnitude decides each result. Directed pairs isolate the cases that are easy to get wrong:

- the signed-zero pair;
- adjacent subnormal encodings;
- an infinity next to a signalling NaN that differs from it only in the mantissa;
- same-class NaN pairs of each sign, which give different results;
- operand words whose upper half decodes to the opposite answer in single precision, which shows that the format select really switches the field boundaries.

// File: rtl/fpgt_pkg.sv
package fpgt_pkg;

  // Field widths of the two supported encodings
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int HP_EXP_W = 5;
  localparam int HP_MAN_W = 10;
  localparam int SP_W     = SP_EXP_W + SP_MAN_W + 1;
  localparam int HP_W     = HP_EXP_W + HP_MAN_W + 1;
  // Magnitude width shared by both paths (the widest non-sign body)
  localparam int MAG_W    = SP_W - 1;

  typedef struct packed {
    logic sign;
    logic nan;
    logic quiet;
    logic zero;
  } fp_class_t;

  // Ranking decision used when at least one operand is a NaN
  function automatic logic nan_rank_gt(fp_class_t a, fp_class_t b);
    logic base;
    if (a.sign != b.sign) return !a.sign;
    base = (a.nan && !b.nan) || (a.quiet && !b.quiet);
    return a.sign ? !base : base;
  endfunction

  // Numeric decision for two non-NaN operands given sign and magnitude
  function automatic logic numeric_gt(fp_class_t a, fp_class_t b,
                                      logic [MAG_W-1:0] a_mag,
                                      logic [MAG_W-1:0] b_mag);
    if (a.zero && b.zero) return 1'b0;
    if (a.sign != b.sign) return !a.sign;
    if (!a.sign) return a_mag > b_mag;
    return a_mag < b_mag;
  endfunction

endpackage

// File: rtl/fpgt_unpack.sv
module fpgt_unpack
  import fpgt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 31
) (
  input  logic [EXP_W+MAN_W:0] word_i,
  output fp_class_t            cls_o,
  output logic [OUT_W-1:0]     mag_o
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_nz;

  assign exp_f    = word_i[W-2:MAN_W];
  assign man_f    = word_i[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_nz   = |man_f;

  always_comb begin
    cls_o.sign  = word_i[W-1];
    cls_o.nan   = exp_ones && man_nz;
    cls_o.quiet = exp_ones && man_nz && man_f[MAN_W-1];
    cls_o.zero  = exp_zero && !man_nz;
  end

  // Exponent:mantissa body is monotonic in magnitude, subnormals included
  assign mag_o = OUT_W'(word_i[W-2:0]);

endmodule

// File: rtl/fpgt_decide.sv
module fpgt_decide
  import fpgt_pkg::*;
(
  input  fp_class_t        a_cls,
  input  fp_class_t        b_cls,
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  output logic             any_nan_o,
  output logic             gt_o
);
  logic nan_gt;
  logic num_gt;

  assign any_nan_o = a_cls.nan || b_cls.nan;
  assign nan_gt    = nan_rank_gt(a_cls, b_cls);
  assign num_gt    = numeric_gt(a_cls, b_cls, a_mag, b_mag);
  assign gt_o      = any_nan_o ? nan_gt : num_gt;

endmodule

// File: rtl/fpgt_compare.sv
module fpgt_compare
  import fpgt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_half,
  input  logic [31:0] a_word,
  input  logic [31:0] b_word,
  output logic        gt_out
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][SP_W-1:0]  op_word;
  fp_class_t [NOPS-1:0]       sp_cls;
  fp_class_t [NOPS-1:0]       hp_cls;
  logic [NOPS-1:0][MAG_W-1:0] sp_mag;
  logic [NOPS-1:0][MAG_W-1:0] hp_mag;
  fp_class_t [NOPS-1:0]       sel_cls;
  logic [NOPS-1:0][MAG_W-1:0] sel_mag;

  // Named internal events for the checker
  fp_class_t a_cls;
  fp_class_t b_cls;
  logic      any_nan;
  logic      gt_comb;

  assign op_word[0] = a_word;
  assign op_word[1] = b_word;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fpgt_unpack #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W), .OUT_W(MAG_W)) sp_i (
      .word_i(op_word[k]),
      .cls_o (sp_cls[k]),
      .mag_o (sp_mag[k])
    );
    fpgt_unpack #(.EXP_W(HP_EXP_W), .MAN_W(HP_MAN_W), .OUT_W(MAG_W)) hp_i (
      .word_i(op_word[k][HP_W-1:0]),
      .cls_o (hp_cls[k]),
      .mag_o (hp_mag[k])
    );
    assign sel_cls[k] = fmt_half ? hp_cls[k] : sp_cls[k];
    assign sel_mag[k] = fmt_half ? hp_mag[k] : sp_mag[k];
  end

  assign a_cls = sel_cls[0];
  assign b_cls = sel_cls[1];

  fpgt_decide decide_i (
    .a_cls    (a_cls),
    .b_cls    (b_cls),
    .a_mag    (sel_mag[0]),
    .b_mag    (sel_mag[1]),
    .any_nan_o(any_nan),
    .gt_o     (gt_comb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gt_out <= 1'b0;
      else        gt_out <= gt_comb;
    end
  end else begin : g_comb
    assign gt_out = gt_comb;
  end

endmodule

// File: rtl/fpgt_checker.sv
module fpgt_checker
  import fpgt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic      clk,
  input logic      rst_n,
  input fp_class_t a_cls,
  input fp_class_t b_cls,
  input logic      any_nan,
  input logic      gt_comb,
  input logic      gt_out
);

  p_nan_sign_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_nan && (a_cls.sign != b_cls.sign)) |-> (gt_comb == !a_cls.sign));

  p_zero_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cls.zero && b_cls.zero) |-> !gt_comb);

  p_pos_qnan_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cls.quiet && !a_cls.sign && !(b_cls.quiet && !b_cls.sign)) |-> gt_comb);

  p_neg_qnan_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cls.quiet && a_cls.sign && !b_cls.nan) |-> !gt_comb);

  if (REG_OUT) begin : g_reg_chk
    p_reg_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (gt_out == $past(gt_comb)));
  end else begin : g_comb_chk
    p_comb_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gt_out == gt_comb);
  end

endmodule

bind fpgt_compare fpgt_checker #(.REG_OUT(REG_OUT)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_cls  (a_cls),
  .b_cls  (b_cls),
  .any_nan(any_nan),
  .gt_comb(gt_comb),
  .gt_out (gt_out)
);

// File: tb/fpgt_compare_tb_top.sv
module fpgt_compare_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_half = 1'b0;
  logic [31:0] a_word = '0;
  logic [31:0] b_word = '0;
  logic        gt_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        fmt;
    logic [31:0] a;
    logic [31:0] b;
    logic        exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpgt_compare dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_half(fmt_half),
    .a_word  (a_word),
    .b_word  (b_word),
    .gt_out  (gt_out)
  );

  // Independent model: map each operand to a (tier, signed key) rank
  function automatic void rank_of(input logic fmt, input logic [31:0] w,
                                  output int tier, output longint key);
    int          ew, mw;
    logic [31:0] body, mant, expo;
    logic        s;
    ew   = fmt ? 5 : 8;
    mw   = fmt ? 10 : 23;
    body = fmt ? {17'b0, w[14:0]} : {1'b0, w[30:0]};
    s    = fmt ? w[15] : w[31];
    mant = body & ((32'd1 << mw) - 32'd1);
    expo = body >> mw;
    key  = s ? -longint'(body) : longint'(body);
    if (expo == ((32'd1 << ew) - 32'd1) && mant != 0)
      tier = (s ? -1 : 1) * (mant[mw-1] ? 3 : 2);
    else
      tier = 0;
  endfunction

  function automatic logic ref_gt(input logic fmt, input logic [31:0] a,
                                  input logic [31:0] b);
    int ta, tb;
    longint ka, kb;
    rank_of(fmt, a, ta, ka);
    rank_of(fmt, b, tb, kb);
    if (ta != tb) return ta > tb;
    if (ta == 0)  return ka > kb;
    return ta < 0;  // same-class negative NaN pair yields 1, positive pair 0
  endfunction

  function automatic string tag_of(input logic fmt, input logic [31:0] a,
                                   input logic [31:0] b);
    int ta, tb;
    longint ka, kb;
    rank_of(fmt, a, ta, ka);
    rank_of(fmt, b, tb, kb);
    if (ta != 0 || tb != 0) begin
      if ((fmt ? a[15] : a[31]) != (fmt ? b[15] : b[31])) return "R4";
      return (fmt ? a[15] : a[31]) ? "R6" : "R5";
    end
    if (ka == 0 && kb == 0) return "R2";
    if (fmt) return "R7";
    if (a[30:23] == 0 || b[30:23] == 0) return "R3";
    return "R1";
  endfunction

  task automatic push(input logic fmt, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    sb_item_t it;
    @(negedge clk);
    fmt_half = fmt;
    a_word   = a;
    b_word   = b;
    it.fmt = fmt;
    it.a   = a;
    it.b   = b;
    it.exp = ref_gt(fmt, a, b);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: one result per cycle, registered output valid after posedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (gt_out !== it.exp) begin
          errors++;
          $display("FAIL %s: fmt=%0d a=%h b=%h actual=%0b expected=%0b",
                   it.tag, it.fmt, it.a, it.b, gt_out, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  logic [31:0] sp_vals [15];
  logic [31:0] hp_vals [11];

  initial begin
    sp_vals = '{32'h3F800000, 32'h40000000, 32'hBF800000, 32'hC0000000,
                32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000,
                32'h7FC00000, 32'h7F800001, 32'hFFC00000, 32'hFF800001,
                32'h00000001, 32'h00000002, 32'h80000001};
    hp_vals = '{32'h00003C00, 32'hA5A54000, 32'h0000BC00, 32'h12347C00,
                32'h0000FC00, 32'hFFFF7E00, 32'h00007C01, 32'h0000FE00,
                32'h5A5AFC01, 32'h00000001, 32'h00008000};

    // R9: reset holds the output low even when A > B
    fmt_half = 1'b0;
    a_word   = 32'h3F800000;
    b_word   = 32'h00000000;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gt_out !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual=%0b expected=0", gt_out);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corner cases
    push(0, 32'h40000000, 32'h3F800000, "R1");  // 2 > 1
    push(0, 32'hBF800000, 32'hC0000000, "R1");  // -1 > -2
    push(0, 32'h00000000, 32'h80000000, "R2");  // +0 vs -0
    push(0, 32'h80000000, 32'h00000000, "R2");  // -0 vs +0
    push(0, 32'h00000002, 32'h00000001, "R3");
    push(0, 32'h00000001, 32'h00000000, "R3");
    push(0, 32'h7F800001, 32'h7F800000, "R8");  // +sNaN above +inf
    push(0, 32'h7F800000, 32'h7F800001, "R8");
    push(1, 32'h00007C00, 32'h00007BFF, "R8");  // half inf vs max finite
    push(0, 32'h00004000, 32'h7F003C00, "R7");  // single: tiny vs huge
    push(1, 32'h00004000, 32'h7F003C00, "R7");  // half: 2.0 vs 1.0
    push(1, 32'hFFFF3C00, 32'h00004000, "R7");  // upper garbage ignored
    push(0, 32'hFFC00000, 32'hFFC00000, "R6");  // same-class negative pair
    push(0, 32'h7FC00000, 32'h7FC00000, "R5");  // same-class positive pair
    push(0, 32'hFF800001, 32'hFFC00000, "R6");
    push(0, 32'h7FC00000, 32'hFF800001, "R4");

    // All-pairs sweep, both formats
    for (int i = 0; i < 15; i++)
      for (int j = 0; j < 15; j++)
        push(0, sp_vals[i], sp_vals[j], tag_of(0, sp_vals[i], sp_vals[j]));
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 11; j++)
        push(1, hp_vals[i], hp_vals[j], tag_of(1, hp_vals[i], hp_vals[j]));

    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    report();
  end

endmodule